// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block runs one 10-bit successive-approximation converter that six analog inputs share through a 6-to-1 selector. Software picks channels in a 6-bit mask and sets one 16-bit divider value. It then writes the go bit. The sequencer visits the enabled channels from the lowest number upward. For each channel it runs three timed phases: selector settling, converter setup and conversion. It drives the selector code, a converter enable and a one-cycle conversion start strobe. At the end of the conversion phase it samples the converter result into that channel's own result register.

A scan can run once or repeat without end. When the scan repeats, each new pass starts again from the lowest enabled channel. A stop request only takes effect once the conversion in progress has finished, whether software clears the go bit or leaves the repeat mode. When every enabled channel has been converted once, the block sets a sticky flag and can raise a one-cycle interrupt. An emulation suspend input makes the block hold after the current conversion unless the emulation bypass bit is set. The register bus stays usable throughout.

Top module: `adc_scan_seq`

## Requirements
- R1: Phase lengths in clock cycles are: settling (DIV[5:0]+3)*2, setup (DIV[15:0]+1)*2 and conversion (DIV[5:0]+1)*24. conv_en is high during setup and conversion. conv_start is high for exactly the first cycle of conversion, which comes 1+settle+setup cycles after the go write edge.
- R2: After reset, the divider reads 0xFFFF and the mask reads 0x3F. Control, comparator, emulation and result registers read 0. scan_irq and conv_en are low.
- R3: Enabled channels are converted in ascending order. Mask bit n enables channel n, and mux_sel carries the binary channel number.
- R4: Result register n takes conv_result at the end of channel n's conversion phase and otherwise holds its value. The registers of channels that are not converted keep their old contents.
- R5: Writing control bit0 (go) as 1 makes the block busy (control bit4). In single-pass mode (control bit1 = 0), go clears itself and the block goes idle after the last enabled channel.
- R6: In repeat mode (control bit1 = 1), the channel after the last enabled one is the lowest enabled channel, and no further write is needed.
- R7: Writing go = 0 while busy makes go read 0 at once. Busy stays 1 until the conversion in progress finishes and stores its result. No further conversion starts after that.
- R8: Clearing control bit1 while a repeating scan runs stops the block after the current conversion, and go then reads 0.
- R9: Completing a pass sets a sticky flag (control bit3). If the interrupt enable (control bit2) is set, scan_irq pulses for one cycle. Writing 1 to bit3 clears the flag.
- R10: Go reads 0 whenever the mask is 0. A go write made with a zero mask leaves the block idle.
- R11: While emu_suspend is high and emulation register bit0 is 0, the block halts after the current conversion, stays busy and keeps the bus readable. It resumes with the next channel on release. When bit0 is 1, suspend has no effect.
- R12: The word offsets are: control 0x00, comparator target 0x04 (6 bits), lower bound 0x08 (10 bits), upper bound 0x0C (10 bits), divider 0x10, mask 0x14, results for channels 0 to 5 at 0x18 to 0x2C, and emulation 0x30. Bits above each field read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| emu_suspend | input | 1 | Emulation suspend request |
| conv_result | input | 10 | Converter output, sampled at the end of conversion |
| mux_sel | output | 3 | Analog selector channel code |
| conv_en | output | 1 | Converter enable (setup and conversion phases) |
| conv_start | output | 1 | One-cycle strobe at the start of conversion |
| scan_irq | output | 1 | One-cycle end-of-pass interrupt |

## Verification
A wrong phase counter shows up within one channel time. It moves the conv_start strobe away from its cycle or changes the gap between the strobe and the result update. A wrong channel pointer shows at once as a mux_sel code out of ascending order, or as a result written into the wrong register. Errors in the stop, mode-change or suspend decisions appear within one channel time after the request: either an extra conv_start strobe, or busy that fails to drop or drops early. A wrong flag or interrupt path shows at the cycle the last enabled channel completes.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_SETTLE, ST_SETUP, ST_CONV, ST_HALT} seq_state_e;

  // control register bit positions
  localparam int CB_GO   = 0;
  localparam int CB_REP  = 1;
  localparam int CB_IE   = 2;
  localparam int CB_FLAG = 3;
  localparam int CB_BUSY = 4;

  // word offsets (byte offset / 4)
  localparam int W_CTL  = 0;
  localparam int W_TGT  = 1;
  localparam int W_LO   = 2;
  localparam int W_HI   = 3;
  localparam int W_DIV  = 4;
  localparam int W_MASK = 5;
  localparam int W_RES0 = 6;
  localparam int W_EMU  = 12;
endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NCH    = 6,
  parameter int DIV_W  = 16,
  parameter int FINE_W = 6,
  parameter int SEL_W  = 3,
  parameter int CNT_W  = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_req,
  input  logic             rep_mode,
  input  logic [DIV_W-1:0] div,
  input  logic [NCH-1:0]   mask,
  input  logic             suspend,
  input  logic             emu_bypass,
  output logic             busy,
  output logic [SEL_W-1:0] ch,
  output logic             conv_en,
  output logic             conv_start,
  output logic             ev_sample,
  output logic             ev_done,
  output logic             clr_run
);
  // phase arithmetic
  function automatic logic [CNT_W-1:0] settle_len(input logic [DIV_W-1:0] d);
    return CNT_W'((32'(d[FINE_W-1:0]) + 32'd3) * 32'd2);
  endfunction
  function automatic logic [CNT_W-1:0] setup_len(input logic [DIV_W-1:0] d);
    return CNT_W'((32'(d) + 32'd1) * 32'd2);
  endfunction
  function automatic logic [CNT_W-1:0] conv_len(input logic [DIV_W-1:0] d);
    return CNT_W'((32'(d[FINE_W-1:0]) + 32'd1) * 32'd24);
  endfunction
  // lowest enabled channel at or above 'from'; MSB flags a hit
  function automatic logic [SEL_W:0] pick(input logic [NCH-1:0] m, input int from);
    logic [SEL_W:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (i >= from && m[i]) r = {1'b1, SEL_W'(i)};
    return r;
  endfunction

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             rep_lat;
  logic             at_end, last, hold, stop_now;
  logic [SEL_W:0]   nxt_up, nxt_first;
  logic [SEL_W-1:0] nxt_ch;

  always_comb begin
    at_end    = (cnt == '0);
    nxt_up    = pick(mask, int'(ch) + 1);
    nxt_first = pick(mask, 0);
    last      = !nxt_up[SEL_W];
    nxt_ch    = last ? nxt_first[SEL_W-1:0] : nxt_up[SEL_W-1:0];
    hold      = suspend && !emu_bypass;
    stop_now  = !run_req || (mask == '0) || (rep_lat && !rep_mode) || (last && !rep_lat);
    ev_sample = (state == ST_CONV) && at_end;
    ev_done   = ev_sample && last;
    clr_run   = ev_sample && stop_now;
    busy      = (state != ST_IDLE);
    conv_en   = (state == ST_SETUP) || (state == ST_CONV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      ch         <= '0;
      rep_lat    <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= (state == ST_SETUP) && at_end;
      case (state)
        ST_IDLE:
          if (run_req && mask != '0) begin
            ch      <= nxt_first[SEL_W-1:0];
            rep_lat <= rep_mode;
            cnt     <= settle_len(div) - 1'b1;
            state   <= ST_SETTLE;
          end
        ST_SETTLE:
          if (at_end) begin
            cnt   <= setup_len(div) - 1'b1;
            state <= ST_SETUP;
          end else cnt <= cnt - 1'b1;
        ST_SETUP:
          if (at_end) begin
            cnt   <= conv_len(div) - 1'b1;
            state <= ST_CONV;
          end else cnt <= cnt - 1'b1;
        ST_CONV:
          if (at_end) begin
            if (stop_now) state <= ST_IDLE;
            else begin
              ch <= nxt_ch;
              if (hold) state <= ST_HALT;
              else begin
                cnt   <= settle_len(div) - 1'b1;
                state <= ST_SETTLE;
              end
            end
          end else cnt <= cnt - 1'b1;
        ST_HALT:
          if (!run_req) state <= ST_IDLE;
          else if (!hold) begin
            cnt   <= settle_len(div) - 1'b1;
            state <= ST_SETTLE;
          end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int NCH    = 6,
  parameter int RES_W  = 10,
  parameter int DIV_W  = 16,
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              busy,
  input  logic [SEL_W-1:0]  ch,
  input  logic              ev_sample,
  input  logic              ev_done,
  input  logic              clr_run,
  input  logic [RES_W-1:0]  conv_result,
  output logic              run_req,
  output logic              rep_mode,
  output logic [DIV_W-1:0]  div,
  output logic [NCH-1:0]    mask,
  output logic              emu_bypass,
  output logic              irq
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]           word;
  logic                        ie_q, flag_q;
  logic [NCH-1:0]              tgt_q;
  logic [RES_W-1:0]            lo_q, hi_q;
  logic [NCH-1:0][RES_W-1:0]   res_flat;
  wire                         unused_bits = ^{wdata[31:DIV_W], addr[1:0]};

  assign word = addr[ADDR_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_req    <= 1'b0;
      rep_mode   <= 1'b0;
      ie_q       <= 1'b0;
      flag_q     <= 1'b0;
      tgt_q      <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      div        <= '1;
      mask       <= '1;
      emu_bypass <= 1'b0;
      irq        <= 1'b0;
    end else begin
      irq <= ev_done && ie_q;
      if (clr_run) run_req <= 1'b0;
      if (wen) begin
        case (int'(word))
          W_CTL: begin
            run_req  <= wdata[CB_GO] && (mask != '0);
            rep_mode <= wdata[CB_REP];
            ie_q     <= wdata[CB_IE];
            if (wdata[CB_FLAG]) flag_q <= 1'b0;
          end
          W_TGT:  tgt_q      <= wdata[NCH-1:0];
          W_LO:   lo_q       <= wdata[RES_W-1:0];
          W_HI:   hi_q       <= wdata[RES_W-1:0];
          W_DIV:  div        <= wdata[DIV_W-1:0];
          W_MASK: mask       <= wdata[NCH-1:0];
          W_EMU:  emu_bypass <= wdata[0];
          default: ;
        endcase
      end
      if (ev_done) flag_q <= 1'b1;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_res
    logic [RES_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (ev_sample && ch == SEL_W'(n)) q <= conv_result;
    end
    assign res_flat[n] = q;
  end

  always_comb begin
    rdata = '0;
    case (int'(word))
      W_CTL:  rdata[4:0]       = {busy, flag_q, ie_q, rep_mode, run_req && (mask != '0)};
      W_TGT:  rdata[NCH-1:0]   = tgt_q;
      W_LO:   rdata[RES_W-1:0] = lo_q;
      W_HI:   rdata[RES_W-1:0] = hi_q;
      W_DIV:  rdata[DIV_W-1:0] = div;
      W_MASK: rdata[NCH-1:0]   = mask;
      W_EMU:  rdata[0]         = emu_bypass;
      default:
        for (int n = 0; n < NCH; n++)
          if (int'(word) == W_RES0 + n) rdata[RES_W-1:0] = res_flat[n];
    endcase
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH    = 6,
  parameter int RES_W  = 10,
  parameter int DIV_W  = 16,
  parameter int FINE_W = 6,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              emu_suspend,
  input  logic [RES_W-1:0]  conv_result,
  output logic [$clog2(NCH)-1:0] mux_sel,
  output logic              conv_en,
  output logic              conv_start,
  output logic              scan_irq
);
  localparam int SEL_W = $clog2(NCH);
  localparam int CNT_W = DIV_W + 2;

  logic             run_req, rep_mode, emu_bypass, busy;
  logic             ev_sample, ev_done, clr_run;
  logic [DIV_W-1:0] div;
  logic [NCH-1:0]   mask;

  adc_seq_regs #(.NCH(NCH), .RES_W(RES_W), .DIV_W(DIV_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(bus_wen), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .busy(busy), .ch(mux_sel), .ev_sample(ev_sample),
    .ev_done(ev_done), .clr_run(clr_run), .conv_result(conv_result),
    .run_req(run_req), .rep_mode(rep_mode), .div(div), .mask(mask),
    .emu_bypass(emu_bypass), .irq(scan_irq)
  );

  adc_seq_fsm #(.NCH(NCH), .DIV_W(DIV_W), .FINE_W(FINE_W), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .rep_mode(rep_mode), .div(div),
    .mask(mask), .suspend(emu_suspend), .emu_bypass(emu_bypass), .busy(busy),
    .ch(mux_sel), .conv_en(conv_en), .conv_start(conv_start),
    .ev_sample(ev_sample), .ev_done(ev_done), .clr_run(clr_run)
  );
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int NCH   = 6,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             run_req,
  input logic [NCH-1:0]   mask,
  input logic [SEL_W-1:0] mux_sel,
  input logic             conv_en,
  input logic             conv_start,
  input logic             scan_irq
);
  // R9
  scan_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_irq |=> !scan_irq);
  // R1
  start_strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R1
  start_within_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> conv_en);
  // R3
  sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en && $past(busy)) |-> $stable(mux_sel));
  // R10
  zero_mask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mask == '0) |=> !busy);
  // R7
  stopped_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !run_req) |=> !busy);
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .run_req(run_req), .mask(mask),
  .mux_sel(mux_sel), .conv_en(conv_en), .conv_start(conv_start), .scan_irq(scan_irq)
);

// File: tb/adc_scan_seq_test.sv
`timescale 1ns/1ps
module adc_scan_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wen = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        emu_suspend = 1'b0;
  logic [9:0]  conv_result;
  logic [2:0]  mux_sel;
  logic        conv_en, conv_start, scan_irq;
  logic [9:0]  base = 10'h100;

  int errs = 0, checks = 0, pcyc = 0, starts = 0, irqs = 0;
  int seq [16];
  bit done = 0;

  always #2.5 clk = ~clk;
  assign conv_result = base + 10'(mux_sel) * 10'd37;

  adc_scan_seq uut (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .emu_suspend(emu_suspend),
    .conv_result(conv_result), .mux_sel(mux_sel), .conv_en(conv_en),
    .conv_start(conv_start), .scan_irq(scan_irq)
  );

  always @(posedge clk) pcyc++;
  always @(negedge clk) begin
    if (conv_start) begin seq[starts % 16] = int'(mux_sel); starts++; end
    if (scan_irq) irqs++;
  end

  localparam int GO = 1, REP = 2, IE = 4, FLAG = 8, BUSY = 16;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_addr = 6'(a); bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    bus_addr = 6'(a);
    #0.5 v = int'(bus_rdata);
  endtask

  task automatic clr_cnt();
    @(posedge clk);
    starts = 0; irqs = 0;
  endtask

  task automatic wait_idle(int lim);
    int n = 0;
    @(negedge clk);
    bus_addr = 6'h00;
    #0.5;
    while ((bus_rdata & BUSY) != 0 && n < lim) begin @(negedge clk); #0.5; n++; end
  endtask

  task automatic t_reset();
    int v;
    rd(6'h00, v); chk("R2", "control", v, 0);
    rd(6'h10, v); chk("R2", "divider", v, 'hFFFF);
    rd(6'h14, v); chk("R2", "mask", v, 'h3F);
    rd(6'h18, v); chk("R2", "result0", v, 0);
    rd(6'h2C, v); chk("R2", "result5", v, 0);
    rd(6'h30, v); chk("R2", "emulation", v, 0);
    chk("R2", "irq/enable", {scan_irq, conv_en}, 0);
  endtask

  task automatic t_timing();
    int v, p0, tcs, n;
    wr(6'h10, 2); wr(6'h14, 1); base = 10'h100; clr_cnt();
    wr(6'h00, GO | IE); p0 = pcyc;
    bus_addr = 6'h18;
    n = 0;
    while (!conv_start && n < 2000) begin @(negedge clk); n++; end
    tcs = pcyc - p0;
    // R1: settle (2+3)*2=10, setup (2+1)*2=6
    chk("R1", "go-to-start cycles", tcs, 1 + 10 + 6);
    chk("R1", "enable with start", conv_en, 1);
    chk("R3", "selector ch0", mux_sel, 0);
    n = 0;
    while (bus_rdata[9:0] != 10'h100 && n < 2000) begin @(negedge clk); #0.5; n++; end
    // R1 R4: conversion (2+1)*24=72
    chk("R4", "start-to-result cycles", pcyc - p0 - tcs, 72);
    wait_idle(500);
    rd(6'h00, v); chk("R5", "one pass ends, go cleared, flag set", v, FLAG | IE);
    chk("R9", "irq pulses", irqs, 1);
    wr(6'h00, FLAG | IE);
    rd(6'h00, v); chk("R9", "flag cleared by write 1", v, IE);
  endtask

  task automatic t_order();
    int v;
    wr(6'h10, 0); wr(6'h14, 'h2A); base = 10'h200; clr_cnt();
    wr(6'h00, GO);
    rd(6'h00, v); chk("R5", "busy after go", (v & BUSY) != 0, 1);
    wait_idle(2000);
    chk("R3", "conversions", starts, 3);
    chk("R3", "order", seq[0] * 100 + seq[1] * 10 + seq[2], 135);
    rd(6'h1C, v); chk("R4", "result1", v, 'h200 + 37);
    rd(6'h24, v); chk("R4", "result3", v, 'h200 + 3 * 37);
    rd(6'h2C, v); chk("R4", "result5", v, 'h200 + 5 * 37);
    rd(6'h18, v); chk("R4", "result0 untouched", v, 'h100);
    chk("R9", "no irq when disabled", irqs, 0);
    rd(6'h00, v); chk("R9", "flag without enable", v, FLAG);
    wr(6'h00, FLAG);
  endtask

  task automatic t_repeat();
    int v, n, s_at, c;
    wr(6'h14, 'h06); base = 10'h010; clr_cnt();
    wr(6'h00, GO | REP | IE);
    n = 0;
    while (starts < 5 && n < 5000) begin @(negedge clk); n++; end
    chk("R6", "wrap order", seq[0] * 10000 + seq[1] * 1000 + seq[2] * 100 + seq[3] * 10 + seq[4], 12121);
    chk("R6", "irq per pass", irqs >= 2, 1);
    n = 0;
    while (!conv_start && n < 200) begin @(negedge clk); n++; end
    base = 10'h300;
    wr(6'h00, REP | IE);
    s_at = starts; c = seq[(s_at - 1) % 16];
    rd(6'h00, v); chk("R7", "go 0, still busy", v & (GO | BUSY), BUSY);
    wait_idle(500);
    repeat (100) @(negedge clk);
    chk("R7", "no start after stop", starts, s_at);
    rd(6'h18 + 4 * c, v); chk("R7", "current conversion completed", v, 'h300 + 37 * c);
    wr(6'h00, FLAG);
  endtask

  task automatic t_switch();
    int v, n, s_at;
    clr_cnt();
    wr(6'h00, GO | REP);
    n = 0;
    while (starts < 1 && n < 500) begin @(negedge clk); n++; end
    wr(6'h00, GO);
    s_at = starts;
    wait_idle(500);
    repeat (100) @(negedge clk);
    chk("R8", "no start after mode change", starts, s_at);
    rd(6'h00, v); chk("R8", "go cleared", v & (GO | BUSY), 0);
  endtask

  task automatic t_zero();
    int v;
    wr(6'h14, 0); clr_cnt();
    wr(6'h00, GO);
    repeat (20) @(negedge clk);
    rd(6'h00, v); chk("R10", "idle, go reads 0", v & (GO | BUSY), 0);
    chk("R10", "no conversion", starts, 0);
    wr(6'h14, 'h3F);
    rd(6'h00, v); chk("R10", "still idle after mask set", v & (GO | BUSY), 0);
  endtask

  task automatic t_suspend();
    int v, n;
    wr(6'h14, 'h03); wr(6'h30, 0); clr_cnt();
    wr(6'h00, GO);
    n = 0;
    while (starts < 1 && n < 500) begin @(negedge clk); n++; end
    emu_suspend = 1'b1;
    repeat (150) @(negedge clk);
    chk("R11", "halted after current", starts, 1);
    rd(6'h14, v); chk("R11", "bus readable", v, 3);
    rd(6'h00, v); chk("R11", "busy while halted", (v & BUSY) != 0, 1);
    emu_suspend = 1'b0;
    wait_idle(500);
    chk("R11", "resumed to ch1", starts * 10 + seq[1], 21);
    wr(6'h30, 1); clr_cnt();
    emu_suspend = 1'b1;
    wr(6'h00, GO);
    wait_idle(500);
    chk("R11", "bypass ignores suspend", starts, 2);
    emu_suspend = 1'b0;
    wr(6'h00, FLAG);
  endtask

  task automatic t_map();
    int v;
    wr(6'h04, 'h15); rd(6'h04, v); chk("R12", "target", v, 'h15);
    wr(6'h08, -1);   rd(6'h08, v); chk("R12", "lower field width", v, 'h3FF);
    wr(6'h0C, 'h3F0); rd(6'h0C, v); chk("R12", "upper", v, 'h3F0);
    rd(6'h30, v); chk("R12", "emulation", v, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_timing();
    t_order();
    t_repeat();
    t_switch();
    t_zero();
    t_suspend();
    t_map();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule